// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (512 bytes)

This block models a 512-byte serial EEPROM that sits on a two-wire bus as a slave. The system clock samples the bus clock and data lines. The block drives the data line only through a pull-low enable, so an external pull-up resistor provides the high level. Two strap inputs give the device its bus identity. One bit of the device address byte does not select a chip: it supplies the top bit of the 9-bit memory address, which splits the array into two 256-byte halves.

A master writes by sending a device byte and then a word address. Up to sixteen data bytes may follow. The data bytes collect in a page buffer, and the write is committed only when a STOP closes the transfer. The block then enters a self-timed write cycle whose length is a parameter counted in clock cycles. During that cycle it ignores the bus entirely, so a master can poll for completion by addressing the device until it gets an acknowledge. To read, the master either re-addresses the device with the read bit set and continues from the current address, or first sets the address with a dummy write followed by a repeated START.

Top module: `twe_eeprom_slave`

## Requirements
- R1: The device byte is laid out, MSB first, as bits 7..4 = type code 1010, bits 3..2 = strap select, bit 1 = memory address bit 8, and bit 0 = direction (1 read, 0 write). When the type code and both strap bits match, the slave pulls SDA low for the ninth clock.
- R2: When the type code or a strap bit differs, the ninth clock is not acknowledged. The slave then stays off the bus, acknowledging no further byte, until the next START.
- R3: In a write transfer, the slave acknowledges the word address byte and every data byte.
- R4: After a write transfer with one data byte is closed by STOP and the write cycle ends, a read of address {bit 8 from the device byte, word address} returns that byte.
- R5: Within one write transfer, only the low 4 address bits advance after each data byte, wrapping inside the 16-byte page. When more than 16 bytes arrive, the later ones replace the earlier ones in wrap order. Page locations that received no byte keep their old contents.
- R6: A STOP after at least one data byte starts a write cycle lasting WR_CYCLES clocks. During that cycle no START is seen and no byte is acknowledged, whether it is a write or a read address.
- R7: Once the write cycle is over, a matching device byte is acknowledged again.
- R8: A STOP that comes before any data byte, or a repeated START, ends the transfer without a write cycle (the next matching device byte is acknowledged at once) and leaves the array unchanged.
- R9: A read shifts out the byte at the current address MSB first, then increments the full 9-bit address (0x1FF goes to 0x000). Reading continues for as long as the master acknowledges each byte.
- R10: When the master does not acknowledge a read byte, the slave releases SDA and stays released until the next START.
- R11: During reset and right after it, the SDA pull-low enable is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sel_i | input | 2 | Strap select compared with device byte bits 3..2 |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The end of the self-timed write cycle and the arrival of a new transfer can overlap. A poll whose START lands inside the busy window must be ignored even if its device byte finishes after the window closes. The bench provokes this by polling right after the STOP with a write-direction byte and then a read-direction byte, both inside the window, and expecting no acknowledge for either. It then waits past the window and expects the next poll to be acknowledged. A second overlap is the address increment meeting the top of the array during a sequential read. The bench judges this by comparing the byte that follows 0x1FF with what it stored at 0x000.

// File: rtl/twe_pkg.sv
package twe_pkg;

    localparam int unsigned TWE_AW = 9;
    localparam int unsigned TWE_PW = 4;
    localparam int unsigned TWE_DW = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_BUSY
    } twe_state_e;

    function automatic logic dev_hit(input logic [7:0] b,
                                     input logic [3:0] code,
                                     input logic [1:0] sel);
        return (b[7:4] == code) && (b[3:2] == sel);
    endfunction

endpackage

// File: rtl/twe_bus_sync.sv
module twe_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_lvl, sda_lvl;

    assign scl_lvl = sync_q.scl_sh[STAGES-1];
    assign sda_lvl = sync_q.sda_sh[STAGES-1];

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_sh   = {sync_q.scl_sh[STAGES-2:0], scl_i};
        sync_d.sda_sh   = {sync_q.sda_sh[STAGES-2:0], sda_i};
        sync_d.scl_prev = scl_lvl;
        sync_d.sda_prev = sda_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sda_o      = sda_lvl;
    assign scl_rise_o = scl_lvl & ~sync_q.scl_prev;
    assign scl_fall_o = ~scl_lvl & sync_q.scl_prev;
    assign start_o    = scl_lvl & sync_q.scl_prev & ~sda_lvl & sync_q.sda_prev;
    assign stop_o     = scl_lvl & sync_q.scl_prev & sda_lvl & ~sync_q.sda_prev;

    // R1: a clock rising edge is reported for one cycle only
    a_r1_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_o |=> !scl_rise_o);

endmodule

// File: rtl/twe_page_buf.sv
module twe_page_buf #(
    parameter int unsigned PW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o,
    output logic          any_valid_o
);

    localparam int unsigned DEPTH = 1 << PW;

    logic [DEPTH-1:0] valid_d, valid_q;
    logic [DW-1:0]    data_q [DEPTH];

    always_comb begin
        valid_d = valid_q;
        if (clr_i) begin
            valid_d = '0;
        end else if (wr_i) begin
            valid_d[wr_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_i && (wr_idx_i == PW'(g))) begin
                data_q[g] <= wr_data_i;
            end
        end
    end

    assign rd_data_o   = data_q[rd_idx_i];
    assign rd_valid_o  = valid_q[rd_idx_i];
    assign any_valid_o = |valid_q;

    // R8: a clear leaves no slot marked for commit
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (valid_q == '0));

endmodule

// File: rtl/twe_mem_array.sv
module twe_mem_array #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] cells_q [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells_q[raddr_i];

endmodule

// File: rtl/twe_eeprom_slave.sv
module twe_eeprom_slave #(
    parameter int unsigned WR_CYCLES   = 1000,
    parameter logic [3:0]  DEV_CODE    = 4'b1010,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] sel_i,
    output logic       sda_pull_o
);
    import twe_pkg::*;

    localparam int unsigned AW    = TWE_AW;
    localparam int unsigned PW    = TWE_PW;
    localparam int unsigned DW    = TWE_DW;
    localparam int unsigned DEPTH = 1 << PW;
    localparam int unsigned BCW   = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        twe_state_e    st;
        twe_state_e    nxt;
        logic [3:0]    cnt;
        logic [DW-1:0] sh;
        logic [AW-1:0] addr;
        logic          drive;
        logic          mack;
        logic [BCW-1:0] bcnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          sda_s, scl_rise, scl_fall, start_s, stop_s;
    logic          buf_clr, buf_wr, buf_rd_valid, buf_any;
    logic [DW-1:0] buf_rd_data;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic          load_tx;

    twe_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_s),
        .stop_o     (stop_s)
    );

    twe_page_buf #(.PW(PW), .DW(DW)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (buf_clr),
        .wr_i        (buf_wr),
        .wr_idx_i    (ctl_q.addr[PW-1:0]),
        .wr_data_i   (ctl_q.sh),
        .rd_idx_i    (ctl_q.bcnt[PW-1:0]),
        .rd_data_o   (buf_rd_data),
        .rd_valid_o  (buf_rd_valid),
        .any_valid_o (buf_any)
    );

    twe_mem_array #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i ({ctl_q.addr[AW-1:PW], ctl_q.bcnt[PW-1:0]}),
        .wdata_i (buf_rd_data),
        .raddr_i (ctl_q.addr),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        ctl_d   = ctl_q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        mem_we  = 1'b0;
        load_tx = 1'b0;

        if (ctl_q.st == ST_BUSY) begin
            // bus fully ignored; buffer drained into the array one slot per clock
            ctl_d.bcnt = ctl_q.bcnt + 1'b1;
            if ((ctl_q.bcnt < BCW'(DEPTH)) && buf_rd_valid) begin
                mem_we = 1'b1;
            end
            if (ctl_q.bcnt == BCW'(WR_CYCLES - 1)) begin
                ctl_d.st   = ST_IDLE;
                ctl_d.bcnt = '0;
                buf_clr    = 1'b1;
            end
        end else if (start_s) begin
            ctl_d.st    = ST_DEV;
            ctl_d.cnt   = '0;
            ctl_d.drive = 1'b0;
            buf_clr     = 1'b1;
        end else if (stop_s) begin
            ctl_d.cnt   = '0;
            ctl_d.drive = 1'b0;
            ctl_d.bcnt  = '0;
            ctl_d.st    = buf_any ? ST_BUSY : ST_IDLE;
        end else begin
            unique case (ctl_q.st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && (ctl_q.cnt < 4'd8)) begin
                        ctl_d.sh  = {ctl_q.sh[DW-2:0], sda_s};
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end else if (scl_fall && (ctl_q.cnt == 4'd8)) begin
                        ctl_d.cnt = '0;
                        if (ctl_q.st == ST_DEV) begin
                            if (dev_hit(ctl_q.sh, DEV_CODE, sel_i)) begin
                                ctl_d.drive      = 1'b1;
                                ctl_d.addr[AW-1] = ctl_q.sh[1];
                                ctl_d.nxt        = ctl_q.sh[0] ? ST_TX : ST_WADDR;
                                ctl_d.st         = ST_ACK;
                            end else begin
                                ctl_d.st = ST_IDLE;
                            end
                        end else if (ctl_q.st == ST_WADDR) begin
                            ctl_d.addr[DW-1:0] = ctl_q.sh;
                            buf_clr            = 1'b1;
                            ctl_d.drive        = 1'b1;
                            ctl_d.nxt          = ST_WDATA;
                            ctl_d.st           = ST_ACK;
                        end else begin
                            buf_wr               = 1'b1;
                            ctl_d.addr[PW-1:0]   = ctl_q.addr[PW-1:0] + 1'b1;
                            ctl_d.drive          = 1'b1;
                            ctl_d.nxt            = ST_WDATA;
                            ctl_d.st             = ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ctl_d.drive = 1'b0;
                        if (ctl_q.nxt == ST_TX) begin
                            load_tx = 1'b1;
                        end else begin
                            ctl_d.st = ctl_q.nxt;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (ctl_q.cnt == 4'd7) begin
                            ctl_d.drive = 1'b0;
                            ctl_d.cnt   = '0;
                            ctl_d.st    = ST_RACK;
                        end else begin
                            ctl_d.sh    = {ctl_q.sh[DW-2:0], 1'b0};
                            ctl_d.drive = ~ctl_q.sh[DW-2];
                            ctl_d.cnt   = ctl_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ctl_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (ctl_q.mack) begin
                            load_tx = 1'b1;
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (load_tx) begin
            ctl_d.sh    = mem_rdata;
            ctl_d.addr  = ctl_q.addr + 1'b1;
            ctl_d.drive = ~mem_rdata[DW-1];
            ctl_d.cnt   = '0;
            ctl_d.st    = ST_TX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, nxt: ST_IDLE, cnt: '0, sh: '0, addr: '0,
                       drive: 1'b0, mack: 1'b0, bcnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_pull_o = ctl_q.drive;

    logic in_wr_data;
    assign in_wr_data = (ctl_q.st == ST_WDATA) ||
                        ((ctl_q.st == ST_ACK) && (ctl_q.nxt == ST_WDATA));

    // R6: nothing is acknowledged while the write cycle runs
    a_r6_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_BUSY) |-> !sda_pull_o);

    // R10: an idle slave keeps the data line released
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) |-> !sda_pull_o);

    // R5: the page row does not move while data bytes stream in
    a_r5_page_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wr_data && $past(in_wr_data)) |-> $stable(ctl_q.addr[AW-1:PW]));

    // R6: array writes happen only inside the write cycle
    a_r6_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ctl_q.st == ST_BUSY));

endmodule

// File: tb/twe_eeprom_slave_tb_top.sv
module twe_eeprom_slave_tb_top;

    localparam int          WRC = 600;
    localparam int          Q   = 6;
    localparam logic [1:0]  SEL = 2'b10;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic sda_line;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    twe_eeprom_slave #(.WR_CYCLES(WRC)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sel_i      (SEL),
        .sda_pull_o (sda_pull)
    );

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [7:0] model [512];
    logic [7:0] wdat  [32];

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic bit_out(input logic b);
        tick(Q); m_sda = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(~mack);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] devb(input logic page, input logic rw);
        return {4'b1010, SEL, page, rw};
    endfunction

    // write n bytes of wdat starting at a9; model follows the page wrap rule (R5)
    task automatic write_seq(input logic [8:0] a9, input int n, input bit wait_done);
        logic ack;
        bus_start();
        send_byte(devb(a9[8], 1'b0), ack); check("R1 dev ack", ack, 1'b1);
        send_byte(a9[7:0], ack);           check("R3 word addr ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            logic [3:0] lo;
            send_byte(wdat[i], ack);        check("R3 data ack", ack, 1'b1);
            lo = 4'(a9[3:0] + i);
            model[{a9[8:4], lo}] = wdat[i];
        end
        bus_stop();
        if (wait_done) tick(WRC + 40);
    endtask

    task automatic rand_read(input logic [8:0] a9, input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(devb(a9[8], 1'b0), ack); check(req, ack, 1'b1);
        send_byte(a9[7:0], ack);           check(req, ack, 1'b1);
        bus_start();
        send_byte(devb(a9[8], 1'b1), ack); check(req, ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            logic [8:0] ai;
            ai = 9'(a9 + i);
            recv_byte(i != n - 1, d);
            check(req, d, model[ai]);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        check("R11 pull idle in reset", sda_pull, 1'b0);
        rst_n = 1'b1;
        tick(5);
        check("R11 pull idle after reset", sda_pull, 1'b0);
    endtask

    task automatic t_address();
        logic ack;
        bus_start();
        send_byte(devb(1'b0, 1'b0), ack); check("R1 match acked", ack, 1'b1);
        bus_stop();
        bus_start();
        send_byte({4'b1010, 2'b01, 1'b0, 1'b0}, ack); check("R2 strap mismatch", ack, 1'b0);
        send_byte(devb(1'b0, 1'b0), ack);             check("R2 silent until START", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, SEL, 1'b0, 1'b0}, ack); check("R2 type mismatch", ack, 1'b0);
        bus_stop();
    endtask

    task automatic t_byte_write();
        wdat[0] = 8'hA5;
        write_seq(9'h125, 1, 1'b1);
        rand_read(9'h125, 1, "R4 byte write readback");
    endtask

    task automatic t_poll();
        logic ack;
        wdat[0] = 8'h3C;
        write_seq(9'h010, 1, 1'b0);
        bus_start();
        send_byte(devb(1'b0, 1'b0), ack); check("R6 write poll in busy", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(devb(1'b0, 1'b1), ack); check("R6 read poll in busy", ack, 1'b0);
        bus_stop();
        tick(WRC);
        bus_start();
        send_byte(devb(1'b0, 1'b0), ack); check("R7 poll after cycle", ack, 1'b1);
        bus_stop();
        rand_read(9'h010, 1, "R4 polled write readback");
    endtask

    task automatic t_page_write();
        for (int i = 0; i < 16; i++) wdat[i] = 8'(8'h40 + i);
        write_seq(9'h030, 16, 1'b1);
        for (int i = 0; i < 4; i++) wdat[i] = 8'(8'hC0 + i);
        write_seq(9'h03E, 4, 1'b1);
        rand_read(9'h030, 16, "R5 wrap within page");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 16; i++) wdat[i] = 8'h00;
        write_seq(9'h150, 16, 1'b1);
        for (int i = 0; i < 18; i++) wdat[i] = 8'(8'h80 + i);
        write_seq(9'h150, 18, 1'b1);
        rand_read(9'h150, 16, "R5 overflow overwrite");
    endtask

    task automatic t_abort();
        logic ack;
        wdat[0] = 8'h11;
        write_seq(9'h060, 1, 1'b1);
        bus_start();
        send_byte(devb(1'b0, 1'b0), ack); check("R8 dev", ack, 1'b1);
        send_byte(8'h60, ack);            check("R8 addr", ack, 1'b1);
        bus_stop();
        bus_start();
        send_byte(devb(1'b0, 1'b0), ack); check("R8 no cycle after bare STOP", ack, 1'b1);
        send_byte(8'h60, ack);            check("R8 addr again", ack, 1'b1);
        send_byte(8'h77, ack);            check("R8 data acked", ack, 1'b1);
        bus_start();
        send_byte(devb(1'b0, 1'b0), ack); check("R8 repeated START no cycle", ack, 1'b1);
        bus_stop();
        bus_start();
        send_byte(devb(1'b0, 1'b0), ack); check("R8 still not busy", ack, 1'b1);
        bus_stop();
        rand_read(9'h060, 1, "R8 array unchanged");
    endtask

    task automatic t_seq_wrap();
        logic ack;
        logic b;
        logic [7:0] d;
        wdat[0] = 8'h5A;
        write_seq(9'h1FF, 1, 1'b1);
        wdat[0] = 8'hE1; wdat[1] = 8'h96;
        write_seq(9'h000, 2, 1'b1);
        rand_read(9'h1FF, 2, "R9 wrap 1FF to 000");
        bus_start();
        send_byte(devb(1'b0, 1'b1), ack); check("R9 current read dev", ack, 1'b1);
        recv_byte(1'b0, d);               check("R9 current address", d, 8'h96);
        tick(2);
        check("R10 released after NACK", sda_pull, 1'b0);
        bit_in(b);
        check("R10 line high after NACK", b, 1'b1);
        check("R10 pull stays off", sda_pull, 1'b0);
        bus_stop();
    endtask

    initial begin
        tick(10);
        t_reset();
        t_address();
        t_byte_write();
        t_poll();
        t_page_write();
        t_overflow();
        t_abort();
        t_seq_wrap();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule